// File: doc/BRIEF.md
# Inbound BAR Match and Region Mapper

This block sits behind the receive side of a PCI Express endpoint. For each accepted, error-free, address-routed memory or configuration request, it takes the request address and decides where the request lands inside the device. There are two internal destinations:

- Space zero is a fixed, contiguous 16 KB window for local registers and configuration accesses. Its lowest 4 KB holds configuration space.
- Space one is the data-transfer space.

The address is compared against six base address registers (BARs), each with a programmable size mask. In 64-bit mode, adjacent BARs are joined into three pairs.

- A hit on BAR0, or on the pair 0/1 in 64-bit mode, goes straight into space zero. The address sent inward is the offset within the BAR, with no region lookup.
- A hit on any other BAR goes to space one. That BAR is linked to one of four inbound regions. The internal address is the region's start address plus the offset within the BAR.

A small write port loads all settings through a register select (`cfg_sel`):

| Select | Contents |
|---|---|
| 0 to 5 | BAR values |
| 6 to 11 | BAR size masks; a set bit is a compared bit |
| 12 to 15 | Region start addresses |
| 16 | BAR-to-region links; bits [2i+1:2i] give the region for BAR i, i = 1..5 |
| 17 | Control: bit 0 selects 64-bit mode; bits [7:4] are the valid flags of regions 3..0 |

A result comes out one clock after the request. It carries a valid strobe, a miss flag, the space select and a 32-bit internal address.

Top module: `inbound_bar_mapper`

## Requirements
- R1: After reset, `out_valid` is low. Every size mask resets to zero, and a BAR whose mask (or pair of masks in 64-bit mode) is all zero never hits. So the first request after reset misses.
- R2: `out_valid` is high in the cycle after a cycle with `req_valid` and `req_ok` both high, and low in every other cycle.
- R3: A hit on BAR0 gives `out_space` = 0, `out_miss` = 0, and `out_addr` equal to the low 14 bits of the request address with the mask bits cleared, zero-extended.
- R4: In 32-bit mode, a hit on BAR i (i = 1..5) whose linked region r is valid gives `out_space` = 1 and `out_addr` = region r start + (request address bits [31:0] with BAR i's mask bits cleared), modulo 2^32.
- R5: A space-one hit whose linked region has its valid flag clear gives `out_miss` = 1, `out_space` = 0 and `out_addr` = 0.
- R6: A request that hits no BAR gives `out_miss` = 1, `out_space` = 0 and `out_addr` = 0.
- R7: When several BARs hit, the lowest-numbered one decides the result.
- R8: In 64-bit mode (control bit 0 = 1), BAR 2k holds the low 32 bits and BAR 2k+1 the high 32 bits of pair k, with masks paired the same way. Pair 0 maps to space zero. Pairs 1 and 2 map to space one through the region linked to BAR 2 or BAR 4.
- R9: In 32-bit mode, a request whose address bits [63:32] are not all zero hits no BAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 5 | Settings register select |
| cfg_wdata | input | 32 | Settings write data |
| req_valid | input | 1 | Request present |
| req_ok | input | 1 | Request is accepted, error-free, address-routed, memory or configuration |
| req_addr | input | 64 | Request address |
| out_valid | output | 1 | Result strobe |
| out_miss | output | 1 | No usable BAR or region |
| out_space | output | 1 | 0 = register space, 1 = data space |
| out_addr | output | 32 | Internal address |

## Verification
Every result is registered once, so it is due exactly one clock after the request cycle. A settings write takes effect at the clock edge that captures it. The bench drives each request on a falling edge, lets one rising edge pass, and samples all four outputs on the next falling edge. It then drops `req_valid`, so each check sees exactly one result. Requests with `req_ok` low are checked in the same slot for an absent strobe.

// File: rtl/inbound_bar_mapper.sv
module inbound_bar_mapper #(
  parameter int AW        = 32,
  parameter int N_BAR     = 6,
  parameter int N_RGN     = 4,
  parameter int S0_BYTES  = 16384
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic          req_ok,
  input  logic [63:0]   req_addr,
  output logic          out_valid,
  output logic          out_miss,
  output logic          out_space,
  output logic [AW-1:0] out_addr
);
  localparam int S0W    = $clog2(S0_BYTES);
  localparam int RW     = $clog2(N_RGN);
  localparam int IW     = $clog2(N_BAR);
  localparam int N_PAIR = N_BAR / 2;
  localparam int SEL_MASK = N_BAR;
  localparam int SEL_RGN  = 2 * N_BAR;
  localparam int SEL_LINK = SEL_RGN + N_RGN;
  localparam int SEL_CTRL = SEL_LINK + 1;

  logic [AW-1:0] bar_q  [N_BAR];
  logic [AW-1:0] mask_q [N_BAR];
  logic [AW-1:0] rgn_q  [N_RGN];
  logic [RW-1:0] link_q [N_BAR];
  logic [N_RGN-1:0] rgn_ok_q;
  logic          mode64_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_BAR; i++) begin
        bar_q[i]  <= '0;
        mask_q[i] <= '0;
        link_q[i] <= '0;
      end
      for (int r = 0; r < N_RGN; r++) rgn_q[r] <= '0;
      rgn_ok_q <= '0;
      mode64_q <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < N_BAR; i++) begin
        if (cfg_sel == 5'(i))            bar_q[i]  <= cfg_wdata[AW-1:0];
        if (cfg_sel == 5'(SEL_MASK + i)) mask_q[i] <= cfg_wdata[AW-1:0];
        if (cfg_sel == 5'(SEL_LINK))     link_q[i] <= cfg_wdata[RW*i +: RW];
      end
      for (int r = 0; r < N_RGN; r++)
        if (cfg_sel == 5'(SEL_RGN + r)) rgn_q[r] <= cfg_wdata[AW-1:0];
      if (cfg_sel == 5'(SEL_CTRL)) begin
        mode64_q <= cfg_wdata[0];
        rgn_ok_q <= cfg_wdata[4 +: N_RGN];
      end
    end
  end

  logic [N_BAR-1:0]  hit32;
  logic [N_PAIR-1:0] hit64;
  wire upper_zero = (req_addr[63:32] == '0);

  for (genvar i = 0; i < N_BAR; i++) begin : g_h32
    assign hit32[i] = (|mask_q[i]) && upper_zero &&
                      (((req_addr[AW-1:0] ^ bar_q[i]) & mask_q[i]) == '0);
  end

  for (genvar k = 0; k < N_PAIR; k++) begin : g_h64
    wire [2*AW-1:0] m64 = {mask_q[2*k+1], mask_q[2*k]};
    wire [2*AW-1:0] b64 = {bar_q[2*k+1], bar_q[2*k]};
    assign hit64[k] = (|m64) && (((req_addr[2*AW-1:0] ^ b64) & m64) == '0);
  end

  logic          hit;
  logic [IW-1:0] idx;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (mode64_q) begin
      for (int k = N_PAIR - 1; k >= 0; k--)
        if (hit64[k]) begin hit = 1'b1; idx = IW'(2 * k); end
    end else begin
      for (int i = N_BAR - 1; i >= 0; i--)
        if (hit32[i]) begin hit = 1'b1; idx = IW'(i); end
    end
  end

  wire [AW-1:0] off   = req_addr[AW-1:0] & ~mask_q[idx];
  wire [RW-1:0] rsel  = link_q[idx];
  wire          to_s1 = (idx != '0);
  wire          miss  = !hit || (to_s1 && !rgn_ok_q[rsel]);
  wire [AW-1:0] xaddr = to_s1 ? rgn_q[rsel] + off : {{(AW-S0W){1'b0}}, off[S0W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_space <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid && req_ok;
      out_miss  <= miss;
      out_space <= !miss && to_s1;
      out_addr  <= miss ? '0 : xaddr;
    end
  end
endmodule

// File: rtl/inbound_bar_mapper_chk.sv
module inbound_bar_mapper_chk #(
  parameter int AW = 32,
  parameter int S0_BYTES = 16384
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ok,
  input logic          out_valid,
  input logic          out_miss,
  input logic          out_space,
  input logic [AW-1:0] out_addr
);
  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ok) |=> out_valid);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ok) |=> !out_valid);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_addr == '0 && !out_space));
  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss && !out_space) |-> (out_addr < AW'(S0_BYTES)));
endmodule

bind inbound_bar_mapper inbound_bar_mapper_chk #(.AW(AW), .S0_BYTES(S0_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ok(req_ok),
  .out_valid(out_valid), .out_miss(out_miss), .out_space(out_space), .out_addr(out_addr)
);

// File: tb/tb_inbound_bar_mapper.sv
`timescale 1ns/1ps
module tb_inbound_bar_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic        req_ok = 0;
  logic [63:0] req_addr = 0;
  logic        out_valid, out_miss, out_space;
  logic [31:0] out_addr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  inbound_bar_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ok(req_ok), .req_addr(req_addr),
    .out_valid(out_valid), .out_miss(out_miss), .out_space(out_space), .out_addr(out_addr)
  );

  localparam int NV = 8;
  // vectors: 0,1 R3; 2 R7 (BAR1 over BAR2); 3 R4; 4 R5; 5 R6; 6 R9; 7 R2
  localparam logic [63:0] V_ADDR [NV] = '{64'h0000_0000_1000_1234, 64'h0000_0000_1000_3FFC,
    64'h0000_0000_2001_0040, 64'h0000_0000_2050_0000, 64'h0000_0000_4000_0010,
    64'h0000_0000_5000_0000, 64'h0000_0001_1000_1234, 64'h0000_0000_1000_1234};
  localparam logic V_OK    [NV] = '{1, 1, 1, 1, 1, 1, 1, 0};
  localparam logic V_VAL   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0};
  localparam logic V_MISS  [NV] = '{0, 0, 0, 0, 1, 1, 1, 0};
  localparam logic V_SPACE [NV] = '{0, 0, 1, 1, 0, 0, 0, 0};
  localparam logic [31:0] V_XA [NV] = '{32'h0000_1234, 32'h0000_3FFC, 32'h9001_0040,
    32'h8050_0000, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam string V_TAG [NV] = '{"R3", "R3", "R7", "R4", "R5", "R6", "R9", "R2"};

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic req_chk(input logic [63:0] a, input logic ok, input logic ev, input logic em,
                         input logic es, input logic [31:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1; req_ok = ok; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (out_valid !== ev || (ev && (out_miss !== em || out_space !== es || out_addr !== ea))) begin
      errors++;
      $display("FAIL %s addr=%h got v=%b m=%b s=%b a=%h exp v=%b m=%b s=%b a=%h",
               tag, a, out_valid, out_miss, out_space, out_addr, ev, em, es, ea);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset out_valid got %b exp 0", out_valid);
    end
    rst_n = 1;
    // R1: all masks zero after reset, so BAR0 at value 0 still misses
    req_chk(64'h0, 1, 1, 1, 0, 32'h0, "R1");
    wr(0, 32'h1000_0000); wr(6, 32'hFFFF_C000);
    wr(1, 32'h2000_0000); wr(7, 32'hFFF0_0000);
    wr(2, 32'h2000_0000); wr(8, 32'hFF00_0000);
    wr(3, 32'h4000_0000); wr(9, 32'hFFFF_0000);
    wr(13, 32'h8000_0000); wr(14, 32'h9000_0000); wr(15, 32'hA000_0000);
    wr(16, 32'h0000_00D8);
    wr(17, 32'h0000_0060);
    for (int i = 0; i < NV; i++)
      req_chk(V_ADDR[i], V_OK[i], V_VAL[i], V_MISS[i], V_SPACE[i], V_XA[i], V_TAG[i]);
    // R2: valid without ok gives no strobe
    req_chk(64'h0000_0000_2001_0040, 0, 0, 0, 0, 32'h0, "R2");
    // R4: wrap of region start plus offset
    wr(13, 32'hFFFF_FF00);
    req_chk(64'h0000_0000_2050_0200, 1, 1, 0, 1, 32'h0050_0100, "R4");
    wr(13, 32'h8000_0000);
    // R8: 64-bit mode pairs
    wr(17, 32'h0000_0061);
    wr(7, 32'hFFFF_FFFF); wr(1, 32'h0);
    wr(2, 32'h0); wr(8, 32'hFFF0_0000);
    wr(3, 32'h5); wr(9, 32'hFFFF_FFFF);
    req_chk(64'h0000_0005_0001_2340, 1, 1, 0, 1, 32'h8001_2340, "R8");
    req_chk(64'h0000_0000_1000_0100, 1, 1, 0, 0, 32'h0000_0100, "R8");
    req_chk(64'h0000_0006_0001_2340, 1, 1, 1, 0, 32'h0, "R8");
    req_chk(64'h0000_0001_1000_0100, 1, 1, 1, 0, 32'h0, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule